// File: doc/BRIEF.md
# I2C Slave Event Flag and Interrupt Register Block

This block is the processor-facing side of an I2C slave. It keeps a control register, two status registers, a receive/transmit data register and two own-address registers. The protocol engine drives one-cycle strobes for each bus event: an address match, a byte received, a byte sent, a missing acknowledge, a stop, and a bus error. The block turns these strobes into sticky flags and combines them into one interrupt line.

Software clears a flag by making a fixed sequence of accesses, not by writing ones to it. A status read alone clears the address-match and acknowledge-failure flags. The byte-finished flag needs a read of the first status register followed immediately by the data access that matches the transfer direction. The second status register clears when it is read. Control bits other than enable are locked while the block is disabled, so turning the block on takes two writes. Clearing enable wipes every flag.

Register map (3-bit address): 0 control, 1 first status, 2 second status, 3 data, 4 own address low byte, 5 own address high/config. Reads of any other address return 0. Read data is combinational from the current state. Clears and updates take effect at the next clock edge.

Top module: `slv_evt_unit`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0, and all configuration outputs are 0.
- R2: Control register bits are: bit0 enable, bit1 acknowledge enable, bit2 interrupt enable. A write with bit0=1 while the block is disabled sets only enable. Bits 1 and 2 take the written value only when enable is already 1.
- R3: Writing the control register with bit0=0 clears all control bits, every flag and the sequence tracker. Events are ignored while the block is disabled.
- R4: An address-match strobe sets first-status bit1. Reading the first status register clears it.
- R5: A received-byte strobe sets first-status bit2, clears the direction bit3, and captures the byte, which a data read returns. Bit2 clears only when a first-status read is followed, as the very next register access, by a data read.
- R6: A sent-byte strobe sets first-status bit2 and direction bit3. Bit2 clears only when a first-status read is followed, as the very next register access, by a data write. A data write sets `tx_data_o` on the next cycle.
- R7: Any register access other than the completing data access restarts the sequence, and bit2 stays set. This includes a data access of the wrong direction and a read of the second status register.
- R8: An acknowledge-failure strobe sets first-status bit4. Reading the first status register clears it.
- R9: The second status register has bit0 stop seen and bit1 bus error. Reading that register clears both.
- R10: First-status bit0 is the OR of the address-match, byte-finished, acknowledge-failure, stop and bus-error flags. `irq_o` equals that OR ANDed with interrupt enable.
- R11: When an event strobe and a clearing access hit the same flag in the same cycle, the flag ends up set.
- R12: Register 5 holds a clock-select field in bits 4:2 and the two upper address bits in bits 1:0. `own_addr_o` is {bits 1:0 of register 5, register 4} and `clk_sel_o` is bits 4:2 of register 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ev_addr_hit | input | 1 | Engine: own address matched |
| ev_rx_byte | input | 1 | Engine: byte received |
| ev_rx_data | input | 8 | Engine: received byte |
| ev_tx_byte | input | 1 | Engine: byte sent |
| ev_ack_fail | input | 1 | Engine: no acknowledge from master |
| ev_stop | input | 1 | Engine: stop condition seen |
| ev_bus_err | input | 1 | Engine: misplaced start/stop |
| tx_data_o | output | 8 | Byte to transmit |
| own_addr_o | output | 10 | Own slave address |
| clk_sel_o | output | 3 | Clock-frequency selection |
| ack_en_o | output | 1 | Acknowledge enable to engine |
| irq_o | output | 1 | Interrupt request |

## Verification
If the sequence tracker holds the wrong state, the byte-finished flag clears on a bare data access, or it survives a correct sequence. Either error shows in the very next first-status read and in `irq_o` one cycle after the access. A wrong control lock shows up when the control register is read back after the first enabling write. A lost set-over-clear priority drops an event that raced a status read, which the following status read exposes. Random interleaving of events and accesses against a bench model catches the rarer orderings.

// File: rtl/slv_evt_pkg.sv
package slv_evt_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned CSEL_W = 3;
  localparam int unsigned AHI_W  = 2;

  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_STATA = 3'd1;
  localparam logic [REG_AW-1:0] A_STATB = 3'd2;
  localparam logic [REG_AW-1:0] A_DATA  = 3'd3;
  localparam logic [REG_AW-1:0] A_OLO   = 3'd4;
  localparam logic [REG_AW-1:0] A_OHI   = 3'd5;

  typedef struct packed {
    logic ie;
    logic ack;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic bus_err;
    logic stop;
    logic ack_fail;
    logic tx_mode;
    logic xfer;
    logic addr_hit;
  } flags_t;
endpackage

// File: rtl/slv_evt_rsync.sv
module slv_evt_rsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n_in) begin
        if (!rst_n_in) sync_q <= '0;
        else           sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n_in) begin
        if (!rst_n_in) sync_q <= '0;
        else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/slv_evt_ctrl.sv
module slv_evt_ctrl
  import slv_evt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_olo,
  input  logic              wr_ohi,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic              kill,
  output logic [DATA_W-1:0] olo_q,
  output logic [CSEL_W-1:0] csel_q,
  output logic [AHI_W-1:0]  ahi_q
);
  localparam int unsigned OHI_W = CSEL_W + AHI_W;

  ctrl_t             ctrl_d;
  logic [OHI_W-1:0]  ohi_q;

  // Control: everything but enable is locked until enable is already set
  always_comb begin
    ctrl_d = ctrl_q;
    if (!wdata[0]) begin
      ctrl_d = '0;
    end else if (!ctrl_q.en) begin
      ctrl_d = '{ie: 1'b0, ack: 1'b0, en: 1'b1};
    end else begin
      ctrl_d = '{ie: wdata[2], ack: wdata[1], en: 1'b1};
    end
  end

  assign kill = !ctrl_q.en || (wr_ctrl && !wdata[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      olo_q <= '0;
    else if (wr_olo) olo_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ohi_q <= '0;
    else if (wr_ohi) ohi_q <= wdata[OHI_W-1:0];
  end

  assign ahi_q  = ohi_q[AHI_W-1:0];
  assign csel_q = ohi_q[OHI_W-1:AHI_W];
endmodule

// File: rtl/slv_evt_flags.sv
module slv_evt_flags
  import slv_evt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              any_acc,
  input  logic              rd_sa,
  input  logic              rd_sb,
  input  logic              rd_dat,
  input  logic              wr_dat,
  input  logic              ev_addr_hit,
  input  logic              ev_rx_byte,
  input  logic [DATA_W-1:0] ev_rx_data,
  input  logic              ev_tx_byte,
  input  logic              ev_ack_fail,
  input  logic              ev_stop,
  input  logic              ev_bus_err,
  output flags_t            flags_q,
  output logic              armed_q,
  output logic [DATA_W-1:0] rx_q,
  output logic              evt
);
  flags_t flags_d;
  logic   armed_d;
  logic   xfer_clr;
  logic   rx_ce;

  // Sequence tracker: a first-status read arms; the next access decides
  assign xfer_clr = armed_q && ((rd_dat && !flags_q.tx_mode) ||
                                (wr_dat &&  flags_q.tx_mode));

  always_comb begin
    armed_d = armed_q;
    if (any_acc) armed_d = rd_sa;
    if (kill)    armed_d = 1'b0;
  end

  // Clears first, sets afterwards so a same-cycle event wins
  always_comb begin
    flags_d = flags_q;
    if (rd_sa) begin
      flags_d.addr_hit = 1'b0;
      flags_d.ack_fail = 1'b0;
    end
    if (xfer_clr) flags_d.xfer = 1'b0;
    if (rd_sb) begin
      flags_d.stop    = 1'b0;
      flags_d.bus_err = 1'b0;
    end
    if (ev_addr_hit) flags_d.addr_hit = 1'b1;
    if (ev_rx_byte) begin
      flags_d.xfer    = 1'b1;
      flags_d.tx_mode = 1'b0;
    end
    if (ev_tx_byte) begin
      flags_d.xfer    = 1'b1;
      flags_d.tx_mode = 1'b1;
    end
    if (ev_ack_fail) flags_d.ack_fail = 1'b1;
    if (ev_stop)     flags_d.stop     = 1'b1;
    if (ev_bus_err)  flags_d.bus_err  = 1'b1;
    if (kill)        flags_d          = '0;
  end

  assign rx_ce = ev_rx_byte && !kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      armed_q <= 1'b0;
    end else begin
      flags_q <= flags_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_q <= '0;
    else if (rx_ce) rx_q <= ev_rx_data;
  end

  assign evt = flags_q.addr_hit | flags_q.xfer | flags_q.ack_fail |
               flags_q.stop | flags_q.bus_err;
endmodule

// File: rtl/slv_evt_unit.sv
module slv_evt_unit
  import slv_evt_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RST_STAGE = 2,
  localparam int unsigned OWN_W    = DATA_W + AHI_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_AW-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 ev_addr_hit,
  input  logic                 ev_rx_byte,
  input  logic [DATA_W-1:0]    ev_rx_data,
  input  logic                 ev_tx_byte,
  input  logic                 ev_ack_fail,
  input  logic                 ev_stop,
  input  logic                 ev_bus_err,
  output logic [DATA_W-1:0]    tx_data_o,
  output logic [OWN_W-1:0]     own_addr_o,
  output logic [CSEL_W-1:0]    clk_sel_o,
  output logic                 ack_en_o,
  output logic                 irq_o
);
  logic              rst_sync_n;
  ctrl_t             ctrl_q;
  logic              kill;
  logic [DATA_W-1:0] olo_q;
  logic [CSEL_W-1:0] csel_q;
  logic [AHI_W-1:0]  ahi_q;
  flags_t            flags_q;
  logic              armed_q;
  logic [DATA_W-1:0] rx_q;
  logic              evt;
  logic [DATA_W-1:0] txd_q;
  logic              wr_ctrl, wr_olo, wr_ohi, wr_dat;
  logic              rd_sa, rd_sb, rd_dat, any_acc;

  slv_evt_rsync #(.STAGES(RST_STAGE)) u_rsync (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_olo  = bus_wr && (bus_addr == A_OLO);
  assign wr_ohi  = bus_wr && (bus_addr == A_OHI);
  assign wr_dat  = bus_wr && (bus_addr == A_DATA);
  assign rd_sa   = bus_rd && (bus_addr == A_STATA);
  assign rd_sb   = bus_rd && (bus_addr == A_STATB);
  assign rd_dat  = bus_rd && (bus_addr == A_DATA);
  assign any_acc = bus_rd || bus_wr;

  slv_evt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_ctrl(wr_ctrl), .wr_olo(wr_olo), .wr_ohi(wr_ohi), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .kill(kill),
    .olo_q(olo_q), .csel_q(csel_q), .ahi_q(ahi_q)
  );

  slv_evt_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .kill(kill), .any_acc(any_acc),
    .rd_sa(rd_sa), .rd_sb(rd_sb), .rd_dat(rd_dat), .wr_dat(wr_dat),
    .ev_addr_hit(ev_addr_hit), .ev_rx_byte(ev_rx_byte), .ev_rx_data(ev_rx_data),
    .ev_tx_byte(ev_tx_byte), .ev_ack_fail(ev_ack_fail), .ev_stop(ev_stop),
    .ev_bus_err(ev_bus_err),
    .flags_q(flags_q), .armed_q(armed_q), .rx_q(rx_q), .evt(evt)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  txd_q <= '0;
    else if (wr_dat)  txd_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_CTRL:  bus_rdata[2:0] = {ctrl_q.ie, ctrl_q.ack, ctrl_q.en};
        A_STATA: bus_rdata[4:0] = {flags_q.ack_fail, flags_q.tx_mode,
                                   flags_q.xfer, flags_q.addr_hit, evt};
        A_STATB: bus_rdata[1:0] = {flags_q.bus_err, flags_q.stop};
        A_DATA:  bus_rdata      = rx_q;
        A_OLO:   bus_rdata      = olo_q;
        A_OHI:   bus_rdata[CSEL_W+AHI_W-1:0] = {csel_q, ahi_q};
        default: bus_rdata      = '0;
      endcase
    end
  end

  assign tx_data_o  = txd_q;
  assign own_addr_o = {ahi_q, olo_q};
  assign clk_sel_o  = csel_q;
  assign ack_en_o   = ctrl_q.ack;
  assign irq_o      = evt && ctrl_q.ie;
endmodule

// File: rtl/slv_evt_unit_chk.sv
module slv_evt_unit_chk
  import slv_evt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              ev_addr_hit,
  input logic              ev_stop,
  input logic              ev_bus_err,
  input ctrl_t             ctrl_q,
  input flags_t            flags_q,
  input logic              ack_en_o,
  input logic              irq_o
);
  logic ctrl_off_wr;
  logic data_acc;
  assign ctrl_off_wr = bus_wr && (bus_addr == A_CTRL) && !bus_wdata[0];
  assign data_acc    = (bus_rd || bus_wr) && (bus_addr == A_DATA);

  // R2
  lock_first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && bus_wdata[0] && !ctrl_q.en)
      |=> (ctrl_q.en && !ack_en_o && !ctrl_q.ie));

  // R3
  disable_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_off_wr |=> (flags_q == '0 && !irq_o && !ack_en_o));

  // R4
  addr_hit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr_hit && ctrl_q.en && !ctrl_off_wr) |=> flags_q.addr_hit);

  // R7
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.xfer && ctrl_q.en && !data_acc && !ctrl_off_wr) |=> flags_q.xfer);

  // R9
  statb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_STATB && !ev_stop && !ev_bus_err)
      |=> (!flags_q.stop && !flags_q.bus_err));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl_q.ie);
endmodule

bind slv_evt_unit slv_evt_unit_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .ev_addr_hit(ev_addr_hit),
  .ev_stop(ev_stop), .ev_bus_err(ev_bus_err), .ctrl_q(ctrl_q),
  .flags_q(flags_q), .ack_en_o(ack_en_o), .irq_o(irq_o)
);

// File: tb/slv_evt_unit_tb.sv
module slv_evt_unit_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ev_addr_hit = 0, ev_rx_byte = 0, ev_tx_byte = 0;
  logic       ev_ack_fail = 0, ev_stop = 0, ev_bus_err = 0;
  logic [7:0] ev_rx_data = '0;
  logic [7:0] tx_data_o;
  logic [9:0] own_addr_o;
  logic [2:0] clk_sel_o;
  logic       ack_en_o, irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model
  bit m_en, m_ack, m_ie, m_ah, m_xf, m_tx, m_af, m_st, m_be, m_arm;
  logic [7:0] m_rx, m_txd, m_olo;
  logic [4:0] m_ohi;

  always #(CLK_P/2) clk = ~clk;

  slv_evt_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_addr_hit(ev_addr_hit), .ev_rx_byte(ev_rx_byte), .ev_rx_data(ev_rx_data),
    .ev_tx_byte(ev_tx_byte), .ev_ack_fail(ev_ack_fail), .ev_stop(ev_stop),
    .ev_bus_err(ev_bus_err), .tx_data_o(tx_data_o), .own_addr_o(own_addr_o),
    .clk_sel_o(clk_sel_o), .ack_en_o(ack_en_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_evt();
    return m_ah | m_xf | m_af | m_st | m_be;
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {5'b0, m_ie, m_ack, m_en};
      3'd1: return {3'b0, m_af, m_tx, m_xf, m_ah, m_evt()};
      3'd2: return {6'b0, m_be, m_st};
      3'd3: return m_rx;
      3'd4: return m_olo;
      3'd5: return {3'b0, m_ohi};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model(input bit rd, input bit wr, input logic [2:0] a,
                       input logic [7:0] wd, input logic [5:0] ev, input logic [7:0] rxd);
    bit kill, xclr;
    kill = !m_en || (wr && a == 3'd0 && !wd[0]);
    xclr = m_arm && ((rd && a == 3'd3 && !m_tx) || (wr && a == 3'd3 && m_tx));
    if (rd || wr) m_arm = rd && a == 3'd1;
    if (rd && a == 3'd1) begin m_ah = 0; m_af = 0; end
    if (xclr) m_xf = 0;
    if (rd && a == 3'd2) begin m_st = 0; m_be = 0; end
    if (ev[0]) m_ah = 1;
    if (ev[1]) begin m_xf = 1; m_tx = 0; end
    if (ev[2]) begin m_xf = 1; m_tx = 1; end
    if (ev[3]) m_af = 1;
    if (ev[4]) m_st = 1;
    if (ev[5]) m_be = 1;
    if (ev[1] && !kill) m_rx = rxd;
    if (kill) {m_ah, m_xf, m_tx, m_af, m_st, m_be, m_arm} = '0;
    if (wr && a == 3'd3) m_txd = wd;
    if (wr && a == 3'd4) m_olo = wd;
    if (wr && a == 3'd5) m_ohi = wd[4:0];
    if (wr && a == 3'd0) begin
      if (!wd[0]) {m_ie, m_ack, m_en} = '0;
      else if (!m_en) m_en = 1;
      else begin m_ie = wd[2]; m_ack = wd[1]; end
    end
  endtask

  task automatic step(input bit rd, input bit wr, input logic [2:0] a,
                      input logic [7:0] wd, input logic [5:0] ev,
                      input logic [7:0] rxd, input string tag);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    {ev_bus_err, ev_stop, ev_ack_fail, ev_tx_byte, ev_rx_byte, ev_addr_hit} = ev;
    ev_rx_data = rxd;
    #1;
    if (rd) chk({tag, " rdata"}, bus_rdata, exp_read(a));
    model(rd, wr, a, wd, ev, rxd);
    @(posedge clk); #1;
    bus_rd = 0; bus_wr = 0;
    {ev_bus_err, ev_stop, ev_ack_fail, ev_tx_byte, ev_rx_byte, ev_addr_hit} = '0;
    chk({tag, " irq"}, irq_o, m_ie & m_evt());
    chk({tag, " ports"}, {ack_en_o, tx_data_o, own_addr_o, clk_sel_o},
        {m_ack, m_txd, m_ohi[1:0], m_olo, m_ohi[4:2]});
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(1, 0, a, 8'h00, 6'h00, 8'h00, tag);
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    step(0, 1, a, d, 6'h00, 8'h00, tag);
  endtask
  task automatic ev(input logic [5:0] e, input logic [7:0] d, input string tag);
    step(0, 0, 3'd0, 8'h00, e, d, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    {m_en, m_ack, m_ie, m_ah, m_xf, m_tx, m_af, m_st, m_be, m_arm} = '0;
    m_rx = '0; m_txd = '0; m_olo = '0; m_ohi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R1");
    // R2 two-write enable
    wr(3'd0, 8'h07, "R2");
    rd(3'd0, "R2");
    wr(3'd0, 8'h07, "R2");
    rd(3'd0, "R2");
    // R4 address match
    ev(6'h01, 8'h00, "R4");
    rd(3'd1, "R4"); rd(3'd1, "R4");
    // R5 receive sequence
    ev(6'h02, 8'hA5, "R5");
    rd(3'd1, "R5"); rd(3'd3, "R5"); rd(3'd1, "R5");
    // R6 transmit sequence
    ev(6'h04, 8'h00, "R6");
    rd(3'd1, "R6"); wr(3'd3, 8'h3C, "R6"); rd(3'd1, "R6");
    // R7 broken sequence
    ev(6'h02, 8'h5E, "R7");
    rd(3'd1, "R7"); rd(3'd2, "R7"); rd(3'd3, "R7"); rd(3'd1, "R7");
    wr(3'd3, 8'h11, "R7"); rd(3'd1, "R7");
    rd(3'd3, "R7"); rd(3'd1, "R7");
    // R8 acknowledge failure
    ev(6'h08, 8'h00, "R8");
    rd(3'd1, "R8"); rd(3'd1, "R8");
    // R9 / R10 second status
    ev(6'h30, 8'h00, "R10");
    rd(3'd1, "R10"); rd(3'd2, "R9"); rd(3'd2, "R9");
    // R11 set wins over clear
    step(1, 0, 3'd1, 8'h00, 6'h01, 8'h00, "R11");
    rd(3'd1, "R11");
    step(1, 0, 3'd2, 8'h00, 6'h10, 8'h00, "R11");
    rd(3'd2, "R11");
    // R12 address/config
    wr(3'd4, 8'h5A, "R12"); wr(3'd5, 8'hFF, "R12");
    rd(3'd4, "R12"); rd(3'd5, "R12");
    // R3 disable wipes
    ev(6'h3F, 8'h77, "R3");
    wr(3'd0, 8'h06, "R3");
    rd(3'd0, "R3"); rd(3'd1, "R3"); rd(3'd2, "R3");
    ev(6'h01, 8'h00, "R3");
    rd(3'd1, "R3");
    wr(3'd0, 8'h01, "R2"); wr(3'd0, 8'h05, "R2"); rd(3'd0, "R2");

    // random interleaving
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [5:0] e;
      logic [2:0] a;
      logic [7:0] d;
      k = $urandom_range(0, 99);
      e = ($urandom_range(0, 2) == 0) ? 6'(1 << $urandom_range(0, 5)) : 6'h00;
      a = 3'($urandom_range(0, 6));
      d = 8'($urandom);
      if (k < 55)      step(1, 0, a, 8'h00, e, d, "R10 random");
      else if (k < 75) step(0, 1, (a == 3'd0) ? 3'd3 : a, d, e, d, "R7 random");
      else if (k < 80) step(0, 1, 3'd0, {d[7:1], ($urandom_range(0, 5) != 0)}, e, d, "R2 random");
      else             step(0, 0, 3'd0, 8'h00, e, d, "R11 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule